// File: doc/BRIEF.md
# Supply Power-Fail Supervisor

This block watches two comparator flags that describe the main supply of a battery-backed static memory. The first flag says the supply has dropped under the level where writes are no longer trusted. The second says it has dropped further, under the level where the memory must run from its backup cell. From these two flags the block drives three outputs: an interrupt request, a memory deselect / write-protect line and a battery-select line.

When the supply sags, the interrupt request is raised straight away. This gives the host a short warning window to finish its work. After a fixed number of clock ticks the memory is deselected. A deeper sag hands the memory over to the battery. When the supply comes back, the battery is released and the interrupt is withdrawn. Write protection stays on through a long recovery wait before normal access returns. Once the warning window has started, it always runs to the end, even if the supply recovers during it. A brief dip therefore always ends in a full recovery sequence, never in a half-open write window.

The interrupt output is an enable for an external pull-down. A high level means the line is pulled low. A low level means the line is left to its pull-up. Reset puts the block in the protected state.

Top module: `pwr_fail_supervisor`

## Requirements
- R1: From normal operation, a high `below_pfd` sampled at a clock edge makes `irq_drive_low` go to 1 after that same edge. `mem_deselect` stays 0 at that point.
- R2: After `irq_drive_low` rises from normal operation, `mem_deselect` rises exactly WARN_CYCLES clock cycles later. During those cycles `irq_drive_low` stays 1 and `mem_deselect` stays 0.
- R3: While `mem_deselect` is 1 and `below_pfd` is sampled high, `mem_deselect` stays 1 in the next cycle.
- R4: While deselected with the interrupt active, a high `below_so` sampled at an edge sets `batt_sel` to 1 after that edge. A low `below_so` sampled while `batt_sel` is 1 clears `batt_sel` after that edge. `batt_sel` is never 1 unless `mem_deselect` and `irq_drive_low` are both 1.
- R5: After the supply returns, `mem_deselect` falls only after RECOVER_CYCLES consecutive cycles in which the interrupt is released and the memory is deselected.
- R6: When deselected without battery, a low `below_pfd` sampled at an edge releases `irq_drive_low` (to 0) after that edge.
- R7: If `below_pfd` returns low during the warning window, the window still completes. Deselection and the full recovery wait follow, so `mem_deselect` does not return to 0 before WARN_CYCLES + 1 + RECOVER_CYCLES cycles after the interrupt rose.
- R8: While reset is active, `mem_deselect` = 1, `irq_drive_low` = 1 and `batt_sel` = 0. After reset, with a good supply, the block goes through the recovery wait before reaching normal operation.
- R9: A high `below_pfd` during the recovery wait pulls `irq_drive_low` back to 1 and keeps the memory deselected. A later return of the supply restarts the full recovery wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_pfd | input | 1 | Supply is under the deselect threshold |
| below_so | input | 1 | Supply is under the battery switchover threshold |
| irq_drive_low | output | 1 | 1 = pull the open-drain interrupt line low |
| mem_deselect | output | 1 | 1 = memory deselected and write protected |
| batt_sel | output | 1 | 1 = memory powered from the backup cell |

## Verification
The assertions assume the two comparator flags are already synchronous to the clock. They also assume the flags are physically ordered: `below_so` is only high while `below_pfd` is high, because the switchover level lies under the deselect level. The stimulus keeps to this rule: it only raises `below_so` inside an interval where `below_pfd` is already high, and it drops it again before `below_pfd` falls. All input changes are made on the falling clock edge. The sequences cover a deep sag into battery mode, a glitch shorter than the warning window, and a fresh sag during the recovery wait. Each of these can be compared cycle by cycle against a behavioural model of the timing windows.

// File: rtl/pwr_fail_supervisor.sv
module pwr_fail_supervisor #(
  parameter int WARN_CYCLES    = 25,
  parameter int RECOVER_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic below_pfd,
  input  logic below_so,
  output logic irq_drive_low,
  output logic mem_deselect,
  output logic batt_sel
);
  localparam int MAXC = (WARN_CYCLES > RECOVER_CYCLES) ? WARN_CYCLES : RECOVER_CYCLES;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] WARN_LAST = CW'(WARN_CYCLES - 1);
  localparam logic [CW-1:0] REC_LAST  = CW'(RECOVER_CYCLES - 1);

  typedef enum logic [2:0] {S_NORMAL, S_WARN, S_PROTECT, S_BATTERY, S_RECOVER} state_t;

  state_t st, st_nx;
  logic [CW-1:0] cnt;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_NORMAL:  if (below_pfd) st_nx = S_WARN;
      S_WARN:    if (cnt == WARN_LAST) st_nx = S_PROTECT;
      S_PROTECT: if (below_so) st_nx = S_BATTERY;
                 else if (!below_pfd) st_nx = S_RECOVER;
      S_BATTERY: if (!below_so) st_nx = S_PROTECT;
      S_RECOVER: if (below_pfd) st_nx = S_PROTECT;
                 else if (cnt == REC_LAST) st_nx = S_NORMAL;
      default:   st_nx = S_PROTECT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_PROTECT;
      cnt <= '0;
    end else begin
      st  <= st_nx;
      cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
    end
  end

  assign irq_drive_low = (st == S_WARN) || (st == S_PROTECT) || (st == S_BATTERY);
  assign mem_deselect  = (st == S_PROTECT) || (st == S_BATTERY) || (st == S_RECOVER);
  assign batt_sel      = (st == S_BATTERY);
endmodule

// File: rtl/pwr_fail_supervisor_chk.sv
module pwr_fail_supervisor_chk #(
  parameter int WARN_CYCLES    = 25,
  parameter int RECOVER_CYCLES = 1000
) (
  input logic clk,
  input logic rst_n,
  input logic below_pfd,
  input logic below_so,
  input logic irq_drive_low,
  input logic mem_deselect,
  input logic batt_sel
);
  int warn_run;
  int rec_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warn_run <= 0;
      rec_run  <= 0;
    end else begin
      warn_run <= (irq_drive_low && !mem_deselect) ? warn_run + 1 : 0;
      rec_run  <= (mem_deselect && !irq_drive_low) ? rec_run + 1 : 0;
    end
  end

  a_r1_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_drive_low && !mem_deselect && below_pfd) |=> (irq_drive_low && !mem_deselect));

  a_r2_warn_bound: assert property (@(posedge clk) disable iff (!rst_n)
    warn_run <= WARN_CYCLES);

  a_r2_deselect_after_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_deselect) |-> (warn_run == WARN_CYCLES));

  a_r3_hold_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_deselect && below_pfd) |=> mem_deselect);

  a_r4_batt_enter: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_deselect && irq_drive_low && below_so) |=> batt_sel);

  a_r4_batt_leave: assert property (@(posedge clk) disable iff (!rst_n)
    (batt_sel && !below_so) |=> !batt_sel);

  a_r4_batt_implies_protect: assert property (@(posedge clk) disable iff (!rst_n)
    batt_sel |-> (mem_deselect && irq_drive_low));

  a_r5_full_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_deselect) |-> (rec_run == RECOVER_CYCLES));

  a_r6_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_deselect && !batt_sel && !below_pfd && !below_so) |=> !irq_drive_low);

  a_r9_redip: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_deselect && !irq_drive_low && below_pfd) |=> (irq_drive_low && mem_deselect));
endmodule

bind pwr_fail_supervisor pwr_fail_supervisor_chk #(
  .WARN_CYCLES(WARN_CYCLES),
  .RECOVER_CYCLES(RECOVER_CYCLES)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .below_pfd(below_pfd),
  .below_so(below_so),
  .irq_drive_low(irq_drive_low),
  .mem_deselect(mem_deselect),
  .batt_sel(batt_sel)
);

// File: tb/pwr_fail_supervisor_tb_top.sv
`timescale 1ns/1ps
module pwr_fail_supervisor_tb_top;
  localparam int WARN = 6;
  localparam int REC  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic below_pfd = 1'b0;
  logic below_so = 1'b0;
  logic irq_drive_low, mem_deselect, batt_sel;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_fail_supervisor #(.WARN_CYCLES(WARN), .RECOVER_CYCLES(REC)) dut_i (
    .clk(clk), .rst_n(rst_n), .below_pfd(below_pfd), .below_so(below_so),
    .irq_drive_low(irq_drive_low), .mem_deselect(mem_deselect), .batt_sel(batt_sel)
  );

  // Behavioural reference: a mode name and a countdown of remaining cycles.
  string m_mode = "prot";
  int m_left = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = "prot";
      m_left = 0;
    end else begin
      if (m_mode == "norm") begin
        if (below_pfd) begin m_mode = "warn"; m_left = WARN; end
      end else if (m_mode == "warn") begin
        m_left--;
        if (m_left == 0) m_mode = "prot";
      end else if (m_mode == "prot") begin
        if (below_so) m_mode = "batt";
        else if (!below_pfd) begin m_mode = "rec"; m_left = REC; end
      end else if (m_mode == "batt") begin
        if (!below_so) m_mode = "prot";
      end else begin
        if (below_pfd) m_mode = "prot";
        else begin
          m_left--;
          if (m_left == 0) m_mode = "norm";
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of every output against the reference.
  always @(negedge clk) begin
    if (!done) begin
      automatic bit e_irq = (m_mode == "warn") || (m_mode == "prot") || (m_mode == "batt");
      automatic bit e_des = (m_mode == "prot") || (m_mode == "batt") || (m_mode == "rec");
      automatic bit e_bat = (m_mode == "batt");
      check(irq_drive_low == e_irq, "R1 R6 irq", irq_drive_low, e_irq);
      check(mem_deselect == e_des, "R2 R3 R5 deselect", mem_deselect, e_des);
      check(batt_sel == e_bat, "R4 batt", batt_sel, e_bat);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R8: reset state
    cyc(3);
    check(mem_deselect && irq_drive_low && !batt_sel, "R8 reset", {irq_drive_low, mem_deselect, batt_sel}, 3'b110);
    rst_n = 1'b1;
    cyc(REC + 4);
    check(!mem_deselect && !irq_drive_low, "R8 post-reset normal", mem_deselect, 0);

    // R1 R2 R3 R4 R6: deep sag into battery mode
    below_pfd = 1'b1;
    cyc(1);
    check(irq_drive_low && !mem_deselect, "R1 immediate irq", irq_drive_low, 1);
    cyc(WARN);
    check(mem_deselect, "R2 deselect after window", mem_deselect, 1);
    cyc(5);
    below_so = 1'b1;
    cyc(1);
    check(batt_sel, "R4 battery on", batt_sel, 1);
    cyc(10);
    below_so = 1'b0;
    cyc(1);
    check(!batt_sel && mem_deselect, "R4 battery off", batt_sel, 0);
    cyc(5);
    check(mem_deselect, "R3 held while low", mem_deselect, 1);
    below_pfd = 1'b0;
    cyc(2);
    check(!irq_drive_low && mem_deselect, "R6 irq released", irq_drive_low, 0);
    cyc(REC + 3);
    check(!mem_deselect, "R5 back to normal", mem_deselect, 0);

    // R7: glitch shorter than the window
    below_pfd = 1'b1;
    cyc(2);
    below_pfd = 1'b0;
    cyc(WARN + REC - 2);
    check(mem_deselect, "R7 still protected", mem_deselect, 1);
    cyc(6);
    check(!mem_deselect, "R7 recovery completes", mem_deselect, 0);

    // R9: new sag during recovery
    below_pfd = 1'b1;
    cyc(WARN + 3);
    below_pfd = 1'b0;
    cyc(REC / 2);
    below_pfd = 1'b1;
    cyc(1);
    check(irq_drive_low && mem_deselect, "R9 re-protect", irq_drive_low, 1);
    cyc(3);
    below_pfd = 1'b0;
    cyc(REC - 2);
    check(mem_deselect, "R9 restarted wait", mem_deselect, 1);
    cyc(6);
    check(!mem_deselect, "R9 normal again", mem_deselect, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    done = 1'b1;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule